// File: doc/BRIEF.md
# Event Counter with Compare Match and Reload

This block is one timer channel that counts edges of an event clock and raises a sticky match flag when the count reaches a programmable compare value. The event clock comes from one of two places. The first is an external, asynchronous pin, which is synchronised into the system clock before its active edge is detected. The second is a one-cycle tick from an internal prescaler, which is already synchronous.

Software-visible settings arrive as plain input ports, with no bus decoding. These are enable, a 4-bit mode code, source select, edge polarity, reload mode, interrupt enable, the preload and compare words, and a flag-clear pulse. After the channel is enabled, the counter reads zero until the first event, and that event loads the preload value. In reload mode, the event after a match returns the count to the preload value, so matches recur at a fixed spacing.

Top module: `evt_match_counter`

## Requirements
- R1: The channel counts only while `enable` is 1 and `mode` equals 4'b0011. With any other mode code, `count` and `flag` keep their values, except that `flag_clr` can still clear the flag.
- R2: With `src_sel`=0, the event source is `event_pin`, passed through a two-stage synchroniser. The count changes at the third rising clock edge after the pin changes. With `src_sel`=1, each cycle in which `presc_tick` is 1 is one event, and it takes effect at that same edge. `invert` does not apply to the tick.
- R3: With `invert`=0, a rising edge of the pin is an event. With `invert`=1, a falling edge is an event.
- R4: After `enable` rises, `count` reads 0. The first event loads `preload` into the counter.
- R5: When reload does not apply, each later event adds 1 to `count`, modulo 2^24 (0xFFFFFF + 1 gives 0).
- R6: With `reload_mode`=1, an event that occurs while `count` equals `compare` loads `preload` (N). The next match (value M) then follows M−N events later.
- R7: `flag` is set at the edge where an event makes `count` equal to `compare`. It stays set until a one-cycle `flag_clr` pulse arrives. When a set and a clear happen in the same cycle, the set wins.
- R8: `irq` is 1 exactly when `flag` and `irq_en` are both 1, in the same cycle.
- R9: While `enable` is 0, `count` and `flag` become 0 at the next edge. Enabling the channel while the pin already rests at its active level produces no event.
- R10: After reset, `count`, `flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; 0 clears the counter and the flag |
| mode | input | 4 | Mode code; 4'b0011 selects event counting |
| src_sel | input | 1 | Event source: 0 = pin, 1 = prescaler tick |
| invert | input | 1 | Pin polarity: 0 = rising edge, 1 = falling edge |
| reload_mode | input | 1 | 1 = reload preload on the event after a match |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| preload | input | 24 | Value loaded on the first event and on reload |
| compare | input | 24 | Match value |
| event_pin | input | 1 | Asynchronous external event input |
| presc_tick | input | 1 | Synchronous one-cycle prescaler pulse |
| count | output | 24 | Current counter value |
| flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
A pin transition reaches `count` at the third edge after it is driven, while a tick reaches it at its own edge. The flag moves at the same edge as the count that matched, and `irq` follows the flag with no extra cycle. A disable takes effect at the next edge. The bench keeps these timings with a behavioural model that stores the pin history in a queue and updates at each rising edge. The model is compared with the outputs at every falling edge. Directed checks sample at the negedge after the edge where each result is due. The latency test samples after the second and third edges to confirm the count moves exactly at the third.

// File: rtl/evt_match_counter.sv
module evt_match_counter #(
  parameter int CW = 24,
  parameter int MW = 4,
  parameter logic [MW-1:0] EVT_MODE = MW'(3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [MW-1:0] mode,
  input  logic          src_sel,
  input  logic          invert,
  input  logic          reload_mode,
  input  logic          irq_en,
  input  logic          flag_clr,
  input  logic [CW-1:0] preload,
  input  logic [CW-1:0] compare,
  input  logic          event_pin,
  input  logic          presc_tick,
  output logic [CW-1:0] count,
  output logic          flag,
  output logic          irq
);

  logic sync_a, sync_b, pin_prev;
  logic first_pending;
  logic pin_edge, active, evt;
  logic [CW-1:0] nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a   <= 1'b0;
      sync_b   <= 1'b0;
      pin_prev <= 1'b0;
    end else begin
      sync_a   <= event_pin;
      sync_b   <= sync_a;
      pin_prev <= sync_b;
    end
  end

  assign pin_edge = invert ? (pin_prev & ~sync_b) : (sync_b & ~pin_prev);
  assign active   = enable && (mode == EVT_MODE);
  assign evt      = active && (src_sel ? presc_tick : pin_edge);

  always_comb begin
    if (first_pending || (reload_mode && count == compare))
      nxt = preload;
    else
      nxt = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count         <= '0;
      first_pending <= 1'b1;
      flag          <= 1'b0;
    end else if (!enable) begin
      count         <= '0;
      first_pending <= 1'b1;
      flag          <= 1'b0;
    end else begin
      if (evt) begin
        count         <= nxt;
        first_pending <= 1'b0;
      end
      flag <= (evt && nxt == compare) || (flag && !flag_clr);
    end
  end

  assign irq = flag & irq_en;

endmodule

// File: rtl/evt_match_counter_chk.sv
module evt_match_counter_chk #(
  parameter int CW = 24,
  parameter int MW = 4,
  parameter logic [MW-1:0] EVT_MODE = MW'(3)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [MW-1:0] mode,
  input logic          flag_clr,
  input logic [CW-1:0] compare,
  input logic [CW-1:0] count,
  input logic          flag
);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0 && !flag)); // R9

  AST_MODE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode != EVT_MODE) |=> $stable(count)); // R1

  AST_MODE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode != EVT_MODE) |=> !$rose(flag)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr && enable) |=> flag); // R7

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> count == $past(compare)); // R7

endmodule

bind evt_match_counter evt_match_counter_chk #(.CW(CW), .MW(MW), .EVT_MODE(EVT_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .flag_clr(flag_clr),
  .compare(compare), .count(count), .flag(flag)
);

// File: tb/evt_match_counter_tb.sv
module evt_match_counter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [3:0] mode = 4'b0011;
  logic src_sel = 1'b0, invert = 1'b0, reload_mode = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [23:0] preload = '0, compare = '0;
  logic event_pin = 1'b0, presc_tick = 1'b0;
  logic [23:0] count;
  logic flag, irq;

  int n_chk = 0, n_err = 0;
  bit cmp_on = 1'b0;
  string phase = "R10 reset";

  always #5 clk = ~clk;

  evt_match_counter u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .src_sel(src_sel),
    .invert(invert), .reload_mode(reload_mode), .irq_en(irq_en), .flag_clr(flag_clr),
    .preload(preload), .compare(compare), .event_pin(event_pin), .presc_tick(presc_tick),
    .count(count), .flag(flag), .irq(irq)
  );

  // behavioural reference
  bit hq[$];
  int unsigned m_cnt;
  bit m_flg, m_first;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = '{0, 0, 0};
      m_cnt = 0; m_flg = 0; m_first = 1;
    end else begin
      bit older, newer, ev, hit;
      older = hq[hq.size()-3];
      newer = hq[hq.size()-2];
      if (src_sel) ev = presc_tick;
      else if (invert) ev = older && !newer;
      else ev = newer && !older;
      ev = ev && enable && (mode == 4'b0011);
      if (!enable) begin
        m_cnt = 0; m_flg = 0; m_first = 1;
      end else begin
        hit = 0;
        if (ev) begin
          if (m_first || (reload_mode && m_cnt == compare)) m_cnt = preload;
          else m_cnt = (m_cnt + 1) % (1 << 24);
          m_first = 0;
          hit = (m_cnt == compare);
        end
        m_flg = hit || (m_flg && !flag_clr);
      end
      hq.push_back(event_pin);
      if (hq.size() > 8) void'(hq.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk({phase, " count (R4/R5)"}, 32'(count), m_cnt);
      chk({phase, " flag (R7)"}, 32'(flag), 32'(m_flg));
      chk({phase, " irq (R8)"}, 32'(irq), 32'(m_flg && irq_en));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pin_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      event_pin = 1'b1; cyc(3);
      event_pin = 1'b0; cyc(3);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      presc_tick = 1'b1; cyc(1);
      presc_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    @(negedge clk);
    chk("R10 reset count", 32'(count), 0);
    chk("R10 reset flag", 32'(flag), 0);
    chk("R10 reset irq", 32'(irq), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cyc(2);

    phase = "R3 R4 R5 rising count";
    preload = 24'd10; compare = 24'd13; irq_en = 1'b1;
    enable = 1'b1; cyc(2);
    @(negedge clk); chk("R4 zero before first event", 32'(count), 0);
    cyc(1);
    pin_pulse(5); cyc(4);
    @(negedge clk);
    chk("R5 count after five events", 32'(count), 14);
    chk("R7 flag after match", 32'(flag), 1);
    chk("R8 irq with enable", 32'(irq), 1);

    phase = "R7 R8 clear and gate";
    cyc(1); flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    @(negedge clk); chk("R7 cleared by pulse", 32'(flag), 0);
    cyc(1); compare = 24'd15; irq_en = 1'b0;
    pin_pulse(1); cyc(4);
    @(negedge clk);
    chk("R7 set at 15", 32'(flag), 1);
    chk("R8 irq masked", 32'(irq), 0);
    cyc(1); irq_en = 1'b1;
    @(negedge clk); chk("R8 irq unmasked", 32'(irq), 1);

    phase = "R1 other mode";
    cyc(1); mode = 4'b0101;
    pin_pulse(3); cyc(4);
    @(negedge clk);
    chk("R1 count held", 32'(count), 15);
    chk("R1 flag held", 32'(flag), 1);
    cyc(1); mode = 4'b0011;

    phase = "R9 disable and re-enable";
    enable = 1'b0; cyc(1);
    @(negedge clk);
    chk("R9 count zero", 32'(count), 0);
    chk("R9 flag zero", 32'(flag), 0);
    cyc(1); event_pin = 1'b1; cyc(5);
    enable = 1'b1; cyc(6);
    @(negedge clk); chk("R9 no spurious event", 32'(count), 0);
    cyc(1); event_pin = 1'b0; cyc(5);
    @(negedge clk); chk("R3 falling ignored", 32'(count), 0);
    cyc(1); event_pin = 1'b1; cyc(5);
    @(negedge clk); chk("R4 first event loads preload", 32'(count), 10);
    cyc(1); event_pin = 1'b0; cyc(3);

    phase = "R3 falling edge mode";
    enable = 1'b0; cyc(1);
    invert = 1'b1; compare = 24'd100; enable = 1'b1; cyc(2);
    event_pin = 1'b1; cyc(5);
    @(negedge clk); chk("R3 rise ignored when inverted", 32'(count), 0);
    cyc(1); event_pin = 1'b0; cyc(5);
    @(negedge clk); chk("R3 fall counted", 32'(count), 10);
    cyc(1); pin_pulse(2); cyc(4);
    @(negedge clk); chk("R3 two more falls", 32'(count), 12);
    cyc(1); invert = 1'b0;

    phase = "R2 R6 reload with tick";
    enable = 1'b0; cyc(1);
    src_sel = 1'b1; preload = 24'd5; compare = 24'd8; reload_mode = 1'b1;
    enable = 1'b1; cyc(1);
    ticks(4);
    @(negedge clk);
    chk("R6 first match", 32'(count), 8);
    chk("R6 flag at first match", 32'(flag), 1);
    cyc(1); flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    ticks(1);
    @(negedge clk);
    chk("R6 reloaded", 32'(count), 5);
    chk("R6 no flag on reload", 32'(flag), 0);
    cyc(1); ticks(3);
    @(negedge clk);
    chk("R6 match after M-N events", 32'(count), 8);
    chk("R6 flag again", 32'(flag), 1);

    phase = "R5 wrap";
    cyc(1); enable = 1'b0; cyc(1);
    reload_mode = 1'b0; preload = 24'hFFFFFE; compare = 24'd0;
    enable = 1'b1; cyc(1);
    ticks(4);
    @(negedge clk);
    chk("R5 wrapped", 32'(count), 1);
    chk("R7 match at zero", 32'(flag), 1);

    phase = "R7 set beats clear";
    cyc(1); enable = 1'b0; cyc(1);
    reload_mode = 1'b1; preload = 24'd0; compare = 24'd0;
    enable = 1'b1; cyc(1);
    ticks(1);
    presc_tick = 1'b1; flag_clr = 1'b1; cyc(1);
    presc_tick = 1'b0; flag_clr = 1'b0;
    @(negedge clk); chk("R7 set wins", 32'(flag), 1);
    cyc(1); flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    @(negedge clk); chk("R7 plain clear", 32'(flag), 0);

    phase = "R2 pin latency";
    cyc(1); src_sel = 1'b0; reload_mode = 1'b0; compare = 24'd100; cyc(4);
    event_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R2 after edge 1", 32'(count), 0);
    @(negedge clk); chk("R2 after edge 2", 32'(count), 0);
    @(negedge clk); chk("R2 after edge 3", 32'(count), 1);
    cyc(2); event_pin = 1'b0; cyc(6);

    finish_run();
  end

endmodule